// File: doc/BRIEF.md
# Interrupt Flag Aggregation Controller

This block gathers one-cycle event pulses from sixty-four fault and wake sources, organised as eight groups of eight, into eight sticky 8-bit status registers. Each status register has its own mask register. The block reduces the unmasked flags of every group to one bit of an 8-bit summary byte, and from that byte it drives an active-low interrupt line. The line is only pulled low while the supply-present input reports that the host supply is up.

Software reaches the registers through a plain register port: an 8-bit address, an 8-bit write bus with a write strobe, and a combinational read bus that follows the address. A status register is cleared by writing ones to the bits to be cleared, so a write of 0xFF empties it. The summary byte is a dedicated output, so that an attached serial shifter can send it as the first byte of every transfer, whatever that transfer does after.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every status register and every mask register reads 0x00, the summary byte is 0x00 and irq_n_o is high.
- R2: An event pulse of one cycle on evt_i[8*k+b] sets bit b of group k, and that bit stays set after the pulse ends until software clears it. The group index k is 0 = group1, 1 = group2, 2 = group3, 3 = CAN-bus group, 4 = group4, 5 = group5, 6 = group6, 7 = group7. The bit is visible on the read bus and in the summary byte after the next rising clock edge.
- R3: A write to a status address clears exactly the bits that are 1 in wdata_i and leaves the others unchanged. A write of 0x00 has no effect and a write of 0xFF clears the whole register.
- R4: If an event and a clearing write hit the same bit in the same cycle, the bit is set after that edge.
- R5: The status registers sit at 0x51 group1, 0x52 group2, 0x53 group3, 0x54 CAN-bus group, 0x55 group7, 0x5A group4, 0x5B group5 and 0x5C group6. Each mask register sits at its status address plus 0x10. Any other address reads 0x00, and a write to it changes no register.
- R6: Mask registers are plain read/write and take the written byte. A bit that is 1 in a mask still latches its event into the status register, but that bit is left out of the summary byte and the interrupt.
- R7: Summary byte bits 7 down to 0 stand for group7, group1, group2, group3, CAN-bus group, group4, group5 and group6. Each bit is the OR of the unmasked set bits of its group.
- R8: irq_n_o is low exactly when supply_ok_i is high and the summary byte is non-zero.
- R9: Bit 6 of the CAN-bus group and bit 5 of group4 are reserved. They never set and always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 64 | Event pulses, bit 8*k+b is bit b of group k |
| supply_ok_i | input | 1 | High while the host supply is present |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| status_byte_o | output | 8 | Summary byte for the serial interface |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
If a status bit is wrong, the summary byte and irq_n_o show it right after the edge at which it went wrong. A readback of the status address shows it too. A masked bit is different. An error there can only be seen through the read bus until its mask is cleared. For that reason the bench reads back every status and mask register at regular intervals, on top of checking the summary byte and the interrupt line in every cycle. If the summary mapping is wrong, the byte will not match a one-hot expectation, and each group is driven alone to show this. An error in the supply gating appears on irq_n_o in the same cycle that supply_ok_i changes.

// File: rtl/irq_agg_pkg.sv
// Package: shared sizes, address map and group layout of the interrupt
// flag aggregation controller. Assumes eight groups of byte-wide flags.
package irq_agg_pkg;
    localparam int NGRP     = 8;
    localparam int GW       = 8;
    localparam int AW       = 8;
    localparam int EVT_W    = NGRP * GW;
    localparam logic [AW-1:0] MASK_OFS = 8'h10;

    // Status address of group k (0=g1 .. 3=CAN, 4=g4, 5=g5, 6=g6, 7=g7).
    function automatic logic [AW-1:0] stat_addr(input int k);
        case (k)
            0:       return 8'h51;
            1:       return 8'h52;
            2:       return 8'h53;
            3:       return 8'h54;
            4:       return 8'h5A;
            5:       return 8'h5B;
            6:       return 8'h5C;
            default: return 8'h55;
        endcase
    endfunction

    // Reserved bits of group k, which never set.
    function automatic logic [GW-1:0] rsvd_bits(input int k);
        case (k)
            3:       return 8'h40;
            4:       return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

    // Position of group k inside the summary byte.
    function automatic int summary_pos(input int k);
        return (k == NGRP - 1) ? NGRP - 1 : NGRP - 2 - k;
    endfunction
endpackage

// File: rtl/irq_group_reg.sv
// Module: one interrupt group, a sticky status byte and its mask byte.
// Events set status bits. A write-one-to-clear strobe clears them, and an
// event in the same cycle wins. Assumes events are synchronous to clk.
module irq_group_reg #(
    parameter int W = 8,
    parameter logic [W-1:0] RSVD = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_we,
    input  logic         mask_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status_o,
    output logic [W-1:0] mask_o,
    output logic         pending_o
);
    logic [W-1:0] clr_bits;
    logic         live_q;

    // Bits selected by a clearing write this cycle.
    always_comb clr_bits = clr_we ? wdata : '0;

    // Sticky status update: clear first, then set, reserved bits held low.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= ((status_o & ~clr_bits) | evt) & ~RSVD;
    end

    // Plain read/write mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_o <= '0;
        else if (mask_we) mask_o <= wdata;
    end

    // Group contributes to the summary when any unmasked flag is set.
    always_comb pending_o = |(status_o & ~mask_o);

    // Marks that the previous cycle was out of reset, for history checks.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ((($past(status_o) & ~$past(clr_bits)) & ~status_o) == '0));

    // R4
    event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ((($past(evt) & ~RSVD) & ~status_o) == '0));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ((status_o & RSVD) == '0));
endmodule

// File: rtl/irq_summary.sv
// Module: builds the summary byte from the per-group pending bits using the
// fixed bit mapping, and gates the active-low interrupt with supply presence.
module irq_summary
    import irq_agg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGRP-1:0] pend_i,
    input  logic            supply_ok_i,
    output logic [NGRP-1:0] summary_o,
    output logic            irq_n_o
);
    // Place each group's pending bit at its summary position.
    always_comb begin
        summary_o = '0;
        for (int k = 0; k < NGRP; k++) summary_o[summary_pos(k)] = pend_i[k];
    end

    // Interrupt low only with supply present and something pending.
    always_comb irq_n_o = !(supply_ok_i && (|summary_o));

    // R7
    summary_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(summary_o) == $countones(pend_i));

    // R8
    irq_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> (supply_ok_i && (pend_i != '0)));
endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the interrupt flag aggregation controller. It decodes the
// register port, instantiates the eight groups and the summary logic.
// Assumes a single-cycle write strobe and a combinational read bus.
module irq_aggregator
    import irq_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             supply_ok_i,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [GW-1:0]    wdata_i,
    output logic [GW-1:0]    rdata_o,
    output logic [NGRP-1:0]  status_byte_o,
    output logic             irq_n_o
);
    logic [NGRP-1:0] stat_we;
    logic [NGRP-1:0] mask_we;
    logic [NGRP-1:0] pend;
    logic [GW-1:0]   stat_q [NGRP];
    logic [GW-1:0]   mask_q [NGRP];

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        localparam logic [AW-1:0] SA = stat_addr(k);
        localparam logic [AW-1:0] MA = SA + MASK_OFS;

        // Write strobe decode for this group's two registers.
        always_comb begin
            stat_we[k] = wr_en_i && (addr_i == SA);
            mask_we[k] = wr_en_i && (addr_i == MA);
        end

        irq_group_reg #(
            .W    (GW),
            .RSVD (rsvd_bits(k))
        ) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (evt_i[k*GW +: GW]),
            .clr_we    (stat_we[k]),
            .mask_we   (mask_we[k]),
            .wdata     (wdata_i),
            .status_o  (stat_q[k]),
            .mask_o    (mask_q[k]),
            .pending_o (pend[k])
        );
    end

    // Read multiplexer, unmapped addresses return zero.
    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NGRP; k++) begin
            if (addr_i == stat_addr(k))            rdata_o = stat_q[k];
            if (addr_i == stat_addr(k) + MASK_OFS) rdata_o = mask_q[k];
        end
    end

    irq_summary u_sum (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_i      (pend),
        .supply_ok_i (supply_ok_i),
        .summary_o   (status_byte_o),
        .irq_n_o     (irq_n_o)
    );

    // R5
    one_write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_we, mask_we}));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |-> irq_n_o);
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] evt = '0;
    logic        sup = 1'b1;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  sbyte;
    logic        irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] ms [8];
    logic [7:0] mm [8];
    logic [7:0] sa [8] = '{8'h51, 8'h52, 8'h53, 8'h54, 8'h5A, 8'h5B, 8'h5C, 8'h55};
    int         spos [8] = '{6, 5, 4, 3, 2, 1, 0, 7};

    always #2 clk = ~clk;

    irq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .supply_ok_i(sup),
        .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .status_byte_o(sbyte), .irq_n_o(irq_n)
    );

    function automatic logic [7:0] rsv(int k);
        return (k == 3) ? 8'h40 : (k == 4) ? 8'h20 : 8'h00;
    endfunction

    function automatic logic [7:0] exp_sum();
        logic [7:0] s = '0;
        for (int k = 0; k < 8; k++) s[spos[k]] = |(ms[k] & ~mm[k]);
        return s;
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] a);
        for (int k = 0; k < 8; k++) begin
            if (a == sa[k]) return ms[k];
            if (a == sa[k] + 8'h10) return mm[k];
        end
        return 8'h00;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge and update the model.
    task automatic step(logic [63:0] e, logic w, logic [7:0] a, logic [7:0] d, logic s);
        logic [7:0] clr;
        evt = e; wr = w; addr = a; wdata = d; sup = s;
        for (int k = 0; k < 8; k++) begin
            clr = (w && a == sa[k]) ? d : 8'h00;
            ms[k] = ((ms[k] & ~clr) | e[8*k +: 8]) & ~rsv(k);
            if (w && a == sa[k] + 8'h10) mm[k] = d;
        end
        @(negedge clk);
        evt = '0; wr = 1'b0;
    endtask

    task automatic chk_out(string req);
        #1;
        chk({req, " summary"}, sbyte, exp_sum());
        chk({req, " irq_n"}, irq_n, !(sup && (exp_sum() != 0)));
    endtask

    task automatic rd(string req, logic [7:0] a, logic [7:0] lit);
        addr = a; wr = 1'b0; evt = '0;
        #1;
        chk(req, rdata, lit);
    endtask

    task automatic readback_all(string req);
        for (int k = 0; k < 8; k++) begin
            rd(req, sa[k], exp_read(sa[k]));
            rd(req, sa[k] + 8'h10, exp_read(sa[k] + 8'h10));
        end
    endtask

    task automatic clear_all();
        for (int k = 0; k < 8; k++) step('0, 1'b1, sa[k], 8'hFF, 1'b1);
        for (int k = 0; k < 8; k++) step('0, 1'b1, sa[k] + 8'h10, 8'h00, 1'b1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] e;
        logic [7:0]  a, d;
        int          r;
        void'($urandom(32'd20250401));
        for (int k = 0; k < 8; k++) begin ms[k] = '0; mm[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        #1;
        chk("R1 summary", sbyte, 8'h00);
        chk("R1 irq_n", irq_n, 1'b1);
        for (int k = 0; k < 8; k++) begin
            rd("R1 status", sa[k], 8'h00);
            rd("R1 mask", sa[k] + 8'h10, 8'h00);
        end

        // R2 single pulse on group1 bit0, held after the source ends
        step(64'h1, 1'b0, 8'h00, 8'h00, 1'b1);
        step('0, 1'b0, 8'h00, 8'h00, 1'b1);
        step('0, 1'b0, 8'h00, 8'h00, 1'b1);
        rd("R2 sticky", 8'h51, 8'h01);
        chk("R7 group1 at bit6", sbyte, 8'h40);
        chk("R8 irq low", irq_n, 1'b0);

        // R8 supply gating
        step('0, 1'b0, 8'h00, 8'h00, 1'b0);
        #1 chk("R8 no supply", irq_n, 1'b1);

        // R3 write-one-to-clear
        step('0, 1'b1, 8'h51, 8'h00, 1'b1);
        rd("R3 zero write", 8'h51, 8'h01);
        step('0, 1'b1, 8'h51, 8'hFF, 1'b1);
        rd("R3 ff write", 8'h51, 8'h00);
        step(64'hF0 << 56, 1'b0, 8'h00, 8'h00, 1'b1);
        step('0, 1'b1, 8'h55, 8'h30, 1'b1);
        rd("R3 partial", 8'h55, 8'hC0);
        chk("R7 group7 at bit7", sbyte, 8'h80);
        step('0, 1'b1, 8'h55, 8'hFF, 1'b1);

        // R4 set wins over clear on group2 bit3
        step(64'h08 << 8, 1'b1, 8'h52, 8'hFF, 1'b1);
        rd("R4 set wins", 8'h52, 8'h08);

        // R6 mask: read back, hides summary and irq, status still latches
        step('0, 1'b1, 8'h62, 8'h0A, 1'b1);
        rd("R6 mask rw", 8'h62, 8'h0A);
        #1 chk("R6 masked summary", sbyte, 8'h00);
        chk("R6 masked irq", irq_n, 1'b1);
        step(64'h02 << 8, 1'b0, 8'h00, 8'h00, 1'b1);
        rd("R6 masked latch", 8'h52, 8'h0A);
        #1 chk("R6 still masked", sbyte, 8'h00);

        // R9 reserved bits
        step({64{1'b1}}, 1'b0, 8'h00, 8'h00, 1'b1);
        rd("R9 can group", 8'h54, 8'hBF);
        rd("R9 group4", 8'h5A, 8'hDF);
        #1 chk("R7 all groups", sbyte, 8'hFF);

        // R5 unmapped addresses
        step('0, 1'b1, 8'h56, 8'hFF, 1'b1);
        step('0, 1'b1, 8'h50, 8'hFF, 1'b1);
        rd("R5 unmapped read", 8'h56, 8'h00);
        rd("R5 unmapped read", 8'h59, 8'h00);
        rd("R5 group5 addr", 8'h5B, 8'hFF);
        rd("R5 group6 addr", 8'h5C, 8'hFF);
        readback_all("R5 readback");

        // R7 one group alone at a time
        for (int k = 0; k < 8; k++) begin
            clear_all();
            e = '0; e[8*k] = 1'b1;
            step(e, 1'b0, 8'h00, 8'h00, 1'b1);
            #1 chk("R7 mapping", sbyte, 8'h01 << spos[k]);
        end
        clear_all();

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            e = {$urandom & $urandom & $urandom & $urandom,
                 $urandom & $urandom & $urandom & $urandom};
            r = $urandom_range(0, 9);
            if (r < 4)      a = sa[$urandom_range(0, 7)];
            else if (r < 8) a = sa[$urandom_range(0, 7)] + 8'h10;
            else            a = 8'($urandom);
            d = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
            step(e, $urandom_range(0, 1) == 1, a, d, $urandom_range(0, 3) != 0);
            chk_out("R2 R3 R4 R6 R7 R8 random");
            if (i % 200 == 199) readback_all("R2 R3 R5 R6 R9 random readback");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule